// File: doc/BRIEF.md
# Collision-Detecting Shared-Line Serial Transmitter

This block sends one byte at a time onto a single serial line that several stations share. Each station can only pull the line low. A pull-up holds the line high when nobody drives it, so a driven 0 always wins over a released 1. The block receives a byte through a valid/ready handshake and waits until the line has been quiet for a fixed time. It then holds off for a random number of bit times before it sends a framed character. While it sends, it reads back the supersampled line and compares it with each bit it drives.

A station that sends a 1 but reads back a 0 has lost arbitration to another station. It releases the line at once, pulses a collision flag and goes back to waiting for a quiet line, keeping the same byte pending. The station that drives the 0 sees nothing wrong and finishes its character. A busy indication from the local receiver also blocks any new start. The receive data path and packet framing live outside this block.

Top module: `collision_uart_tx`

## Requirements
- R1: While reset is held and after it is released, drive_n_o is 1 (line released), tx_ready_o is 1, and done_o and abort_o are 0.
- R2: A byte on tx_data_i is taken at a clock edge where tx_valid_i and tx_ready_o are both 1. From then on tx_ready_o stays 0 until the cycle in which done_o is 1. While tx_ready_o is 1 the line is released.
- R3: No start bit begins unless the line has read high, with rx_busy_i low, at 80 consecutive clock edges (10 bit times of 8 clocks). The start bit appears 82+8k clocks after the last clock edge that saw the line low or rx_busy_i high.
- R4: The random hold-off k is a whole number of bit times from 0 to 15, taken from a free-running 16-bit LFSR. Successive transfers use more than one value of k.
- R5: A character is 10 bit cells of 8 clocks each, in this order: a start bit of 0, then the 8 data bits LSB first, then a stop bit of 1. drive_n_o is 0 only during cells whose bit is 0.
- R6: done_o is 1 for exactly one cycle. That cycle is the one right after the last clock of the stop bit, and the line is released in it.
- R7: The line is compared at the clock edge that ends the 7th clock (phase 6 of 0..7) of each bit cell. If the bit is 1 and the line reads 0 there, abort_o pulses for one cycle in the next cycle and the line is released in that same cycle.
- R8: A low line seen during a cell whose bit is 0, or only in phases 0..5 of a cell whose bit is 1, has no effect: the character completes unchanged.
- R9: After an abort, the same byte is sent again with no new handshake. The retry goes through the full idle wait and a fresh random hold-off, and tx_ready_o stays 0 meanwhile.
- R10: A 1 on rx_busy_i, or a low line, during the idle wait or the hold-off restarts the idle wait. No start bit is sent while rx_busy_i stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Supersample clock, 8 per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Byte offered |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | Block can take a byte |
| line_i | input | 1 | Synchronised shared line level |
| rx_busy_i | input | 1 | Local receiver is taking a frame |
| drive_n_o | output | 1 | 0 pulls the line low, 1 releases it |
| done_o | output | 1 | One-cycle pulse, character sent |
| abort_o | output | 1 | One-cycle pulse, arbitration lost |

## Verification
The bench plays a second station on the wired-AND line and sweeps a forced 0 over every bit cell of a mixed pattern, in three shapes: a whole cell held low, a glitch that ends before the compare phase, and a single low clock right at the compare phase. A design that compares at the wrong phase either aborts on the glitch or misses the single-clock hit. A design that aborts on a 0 cell would also drop characters that it should win. Each start is timed against the last busy or low reading, so the bench catches an idle count that is off by one, a hold-off that is not a whole bit time, or a start that ignores a low pulse or a busy signal during the hold-off. After every abort the bench checks that the original byte comes back without a new handshake.

// File: rtl/cdtx_pkg.sv
package cdtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SENSE,
    ST_BACKOFF,
    ST_SEND
  } tx_state_e;
endpackage

// File: rtl/cdtx_lfsr.sv
module cdtx_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rand_o
);
  logic [WIDTH-1:0] lfsr_q;

  // Galois form, shifts right every clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED[WIDTH-1:0];
    else         lfsr_q <= {1'b0, lfsr_q[WIDTH-1:1]} ^ (lfsr_q[0] ? TAPS[WIDTH-1:0] : '0);
  end

  assign rand_o = lfsr_q[OUT_W-1:0];

  assert_lfsr_alive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/cdtx_idle_mon.sv
module cdtx_idle_mon #(
  parameter int CLKS_PER_BIT = 8,
  parameter int IDLE_BITS    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic busy_i,
  output logic idle_o
);
  localparam int IDLE_CLKS = CLKS_PER_BIT * IDLE_BITS;
  localparam int CW        = $clog2(IDLE_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic          quiet;

  assign quiet = line_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!quiet)                 cnt_q <= '0;
    else if (cnt_q != CW'(IDLE_CLKS)) cnt_q <= cnt_q + 1'b1;
  end

  // current reading also qualifies, so a low pulse cancels immediately
  assign idle_o = (cnt_q == CW'(IDLE_CLKS)) && quiet;

  assert_idle_after_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(line_i && !busy_i));
endmodule

// File: rtl/cdtx_bit_timer.sv
module cdtx_bit_timer #(
  parameter int CLKS_PER_BIT = 8,
  parameter int SAMPLE_PHASE = 6,
  parameter int FRAME_BITS   = 10,
  localparam int PH_W        = $clog2(CLKS_PER_BIT),
  localparam int IDX_W       = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             sample_o,
  output logic             frame_end_o
);
  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             cell_end;

  assign cell_end = phase_q == PH_W'(CLKS_PER_BIT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (!en_i) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (cell_end) begin
      phase_q <= '0;
      idx_q   <= idx_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign idx_o       = idx_q;
  assign sample_o    = en_i && (phase_q == PH_W'(SAMPLE_PHASE));
  assign frame_end_o = en_i && cell_end && (idx_q == IDX_W'(FRAME_BITS - 1));

  assert_idx_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> idx_q < IDX_W'(FRAME_BITS));
endmodule

// File: rtl/collision_uart_tx.sv
module collision_uart_tx #(
  parameter int          DATA_BITS    = 8,
  parameter int          CLKS_PER_BIT = 8,
  parameter int          SAMPLE_PHASE = 6,
  parameter int          IDLE_BITS    = 10,
  parameter int          BACKOFF_W    = 4,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tx_valid_i,
  input  logic [DATA_BITS-1:0] tx_data_i,
  output logic                 tx_ready_o,
  input  logic                 line_i,
  input  logic                 rx_busy_i,
  output logic                 drive_n_o,
  output logic                 done_o,
  output logic                 abort_o
);
  import cdtx_pkg::*;

  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int BO_W       = BACKOFF_W + $clog2(CLKS_PER_BIT) + 1;

  tx_state_e             state_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [BO_W-1:0]       bo_cnt_q;
  logic                  done_q, abort_q;
  logic                  line_idle, sample_stb, frame_end, cur_bit;
  logic [IDX_W-1:0]      bit_idx;
  logic [BACKOFF_W-1:0]  rand_w;

  cdtx_lfsr #(.WIDTH(16), .TAPS(16'hB400), .SEED(LFSR_SEED), .OUT_W(BACKOFF_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rand_o (rand_w)
  );

  cdtx_idle_mon #(.CLKS_PER_BIT(CLKS_PER_BIT), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .busy_i (rx_busy_i),
    .idle_o (line_idle)
  );

  cdtx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT), .SAMPLE_PHASE(SAMPLE_PHASE),
                   .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (state_q == ST_SEND),
    .idx_o       (bit_idx),
    .sample_o    (sample_stb),
    .frame_end_o (frame_end)
  );

  assign cur_bit = frame_q[bit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      frame_q  <= '1;
      bo_cnt_q <= '0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tx_valid_i) begin
          frame_q <= {1'b1, tx_data_i, 1'b0};
          state_q <= ST_SENSE;
        end
        ST_SENSE: if (line_idle) begin
          bo_cnt_q <= BO_W'(rand_w) * BO_W'(CLKS_PER_BIT);
          state_q  <= ST_BACKOFF;
        end
        ST_BACKOFF: begin
          if (!line_idle)          state_q  <= ST_SENSE;
          else if (bo_cnt_q == '0) state_q  <= ST_SEND;
          else                     bo_cnt_q <= bo_cnt_q - 1'b1;
        end
        ST_SEND: begin
          if (sample_stb && cur_bit && !line_i) begin
            abort_q <= 1'b1;   // lost arbitration, byte stays in frame_q
            state_q <= ST_SENSE;
          end else if (frame_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready_o = state_q == ST_IDLE;
  assign drive_n_o  = !((state_q == ST_SEND) && !cur_bit);
  assign done_o     = done_q;
  assign abort_o    = abort_q;

  assert_ready_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> drive_n_o);
  assert_start_after_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && $past(state_q) != ST_SEND) |-> $past(line_idle));
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && abort_o));
  assert_abort_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> drive_n_o);
  assert_abort_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !$past(line_i));
  assert_retry_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !tx_ready_o);
endmodule

// File: tb/collision_uart_tx_test.sv
module collision_uart_tx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, drive_n, done, abort_w;
  logic       other_n = 1'b1;
  logic       busy = 1'b0;
  logic       line;

  int checks = 0, fails = 0, h = 0, cycles = 0;
  bit [15:0] seen_k = '0;

  always #4 clk = ~clk;
  assign line = drive_n & other_n;

  collision_uart_tx uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tx_valid_i (tx_valid),
    .tx_data_i  (tx_data),
    .tx_ready_o (tx_ready),
    .line_i     (line),
    .rx_busy_i  (busy),
    .drive_n_o  (drive_n),
    .done_o     (done),
    .abort_o    (abort_w)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // offer a byte while the line is held low, then release it
  task automatic start_byte(input logic [7:0] d);
    other_n = 1'b0;
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
    other_n = 1'b1; h = 1;
  endtask

  task automatic wait_start();
    int gap, k, guard;
    guard = 0;
    while (drive_n && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (drive_n) h = (other_n && !busy) ? h + 1 : 0;
    end
    gap = h; k = (gap - 82) / 8;
    chk(gap >= 82 && ((gap - 82) % 8) == 0, "R3 start gap", gap, 82);
    chk(k >= 0 && k <= 15, "R4 backoff range", k, 15);
    if (k >= 0 && k <= 15) seen_k[k] = 1'b1;
  endtask

  // mode 0 clean, 1 whole cell low, 2 glitch phases 0..5, 3 low at phase 6 only
  task automatic frame_once(input logic [7:0] d, input int cbit, input int mode,
                            output bit aborted);
    logic [9:0] fr;
    bit exp_ab;
    fr = {1'b1, d, 1'b0};
    exp_ab = (mode == 1 || mode == 3) && fr[cbit];
    aborted = 1'b0;
    wait_start();
    for (int s = 0; s < 80; s++) begin
      int i, p;
      i = s / 8; p = s % 8;
      if (exp_ab && s == 8 * cbit + 7) begin
        chk(abort_w == 1'b1, "R7 abort pulse", abort_w, 1);
        chk(drive_n == 1'b1, "R7 release", drive_n, 1);
        chk(tx_ready == 1'b0, "R9 still pending", tx_ready, 0);
        aborted = 1'b1;
        break;
      end
      chk(abort_w == 1'b0, "R8 no abort", abort_w, 0);
      if (p == 4) chk(drive_n == fr[i], "R5 bit value", drive_n, fr[i]);
      if (s == 0) chk(tx_ready == 1'b0, "R2 busy with byte", tx_ready, 0);
      other_n = 1'b1;
      case (mode)
        1: if (i == cbit) other_n = 1'b0;
        2: if (i == cbit && p <= 5) other_n = 1'b0;
        3: if (i == cbit && p == 6) other_n = 1'b0;
        default: ;
      endcase
      @(negedge clk);
    end
    if (aborted) begin
      other_n = 1'b0;
      @(negedge clk);
      chk(abort_w == 1'b0, "R7 abort one cycle", abort_w, 0);
      repeat (40) @(negedge clk);
      other_n = 1'b1; h = 1;
    end else begin
      other_n = 1'b1;
      chk(done == 1'b1, "R6 done pulse", done, 1);
      chk(drive_n == 1'b1, "R6 released", drive_n, 1);
      chk(tx_ready == 1'b1, "R2 ready again", tx_ready, 1);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
    end
  endtask

  initial begin
    bit ab;
    logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h3C, 8'hC3};
    repeat (3) @(negedge clk);
    chk(drive_n == 1'b1 && tx_ready == 1'b1, "R1 reset outputs", {drive_n, tx_ready}, 3);
    chk(done == 1'b0 && abort_w == 1'b0, "R1 reset pulses", {done, abort_w}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(drive_n == 1'b1 && tx_ready == 1'b1, "R1 after reset", {drive_n, tx_ready}, 3);

    foreach (pats[n]) begin
      start_byte(pats[n]);
      frame_once(pats[n], 0, 0, ab);
    end

    // collision sweep over every cell and three disturbance shapes
    for (int m = 1; m <= 3; m++) begin
      for (int c = 0; c < 10; c++) begin
        logic [7:0] d;
        d = 8'hA5 ^ 8'(c * 17);
        start_byte(d);
        frame_once(d, c, m, ab);
        while (ab) frame_once(d, 0, 0, ab);  // R9 retry, same byte
      end
    end

    // R10 busy holds off any start
    start_byte(8'h69);
    busy = 1'b1;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (!drive_n) chk(1'b0, "R10 start while busy", drive_n, 1);
    end
    chk(drive_n == 1'b1, "R10 held off by busy", drive_n, 1);
    busy = 1'b0; h = 1;
    frame_once(8'h69, 0, 0, ab);

    // R10 low pulse during the hold-off restarts the wait
    start_byte(8'h96);
    repeat (81) @(negedge clk);
    chk(drive_n == 1'b1, "R3 no early start", drive_n, 1);
    other_n = 1'b0;
    @(negedge clk);
    other_n = 1'b1; h = 1;
    frame_once(8'h96, 0, 0, ab);

    chk($countones(seen_k) >= 4, "R4 varied backoff", $countones(seen_k), 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule